// File: doc/BRIEF.md
# Fixed-Interval Averaging Rate Downsampler

This block links a processing element that advances on a fast timestep to one that advances on a slower timestep. The slow period is an integer number `n` of fast periods. Each valid fast sample is multiplied by a reciprocal coefficient close to `1/n` and added into a wide accumulator. At the end of every slow interval the mean of that interval is rounded back to the data format, saturated if it overflows, and placed in an output register for the consumer.

The coefficient is an input, so any integer ratio works, whether or not it is a power of two. The reciprocal is computed outside the block. The slow-interval boundaries come from two strobes. A start strobe clears the running sum. An end strobe moves the result to the output and raises a one-cycle done flag. The output then holds until the next transfer, so a consumer sampling at its own slow rate always reads a stable value.

Data samples are two's-complement fixed point: 32 bits with 8 fractional bits. The coefficient is unsigned, 25 bits wide with 24 fractional bits, so `0x1000000` stands for 1.0.

Top module: `avg_downsampler`

## Requirements
- R1: On the clock edge where `slow_end` is sampled during an open interval, `avg_out` takes the value `round(S / 2^24)`. `S` is the sum of `fast_data * coef` over every cycle of the interval where `fast_vld` is high. Cycles with `fast_vld` low add nothing.
- R2: `slow_start` opens a new interval and discards the previous sum. A valid sample on the same cycle as `slow_start` is the first term of the new interval. When `slow_start` and `slow_end` coincide, that sample is not a term of the interval being closed.
- R3: A valid sample on the same cycle as `slow_end`, with no `slow_start` on that cycle, is the last term of the interval being closed.
- R4: `done` is high for exactly the one cycle that follows the transferring edge, which is the first cycle showing the new `avg_out`. `done` is low in every other cycle.
- R5: `avg_out` keeps its value in every cycle where `done` is low.
- R6: Rounding is half-up. `2^23` is added before the arithmetic right shift by 24. For example, a mean of +1.5 LSB gives +2, and a mean of -1.5 LSB gives -1.
- R7: A rounded result above `0x7FFFFFFF` gives `0x7FFFFFFF`. A rounded result below -2^31 gives `0x80000000`.
- R8: While `rst_n` is low, `avg_out` and `done` are zero on the next edge. A `slow_end` with no `slow_start` since reset or since the previous transfer leaves `avg_out` unchanged and produces no `done`.
- R9: Intervals of non-power-of-two length, with `coef = round(2^24/n)`, give the rounded mean under R1, for interval lengths 1 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_vld | input | 1 | Fast-step sample strobe |
| fast_data | input | 32 | Signed sample, 8 fractional bits |
| coef | input | 25 | Unsigned reciprocal coefficient, 24 fractional bits |
| slow_start | input | 1 | Opens a slow interval and clears the sum |
| slow_end | input | 1 | Closes the interval and transfers the mean |
| avg_out | output | 32 | Registered interval mean |
| done | output | 1 | One-cycle pulse with each new `avg_out` |

## Verification
The hardest case to reach is a single cycle that closes one interval and opens the next, with a valid sample on it. That sample must go only into the new interval, while the old result is still being transferred. Plain start-then-end traffic never reaches this case. The random intervals are therefore chained: the start cycle of one interval often carries the end of the previous one and a sample. Directed cases add half-LSB rounding ties, overflow in both directions, and an end strobe with no open interval, both after reset and after a transfer.

// File: rtl/avg_pkg.sv
// Package: default geometry shared by the downsampler and its bench.
// Assumes data is Q(DATA_W-FRAC_W).FRAC_W and coef is unsigned with COEF_FRAC fraction bits.
package avg_pkg;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_FRAC_W    = 8;
    localparam int DEF_COEF_FRAC = 24;
    localparam int DEF_GUARD_W   = 10;   // headroom for up to 1024 terms
endpackage

// File: rtl/avg_mac.sv
// Multiply-accumulate path: scales each valid sample by coef and sums it.
// Assumes clr marks the first cycle of an interval; a sample on that cycle
// seeds the new sum. close_sum is the total of the interval being closed.
module avg_mac #(
    parameter int DATA_W = 32,
    parameter int COEF_W = 25,
    parameter int ACC_W  = 68
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld,
    input  logic [DATA_W-1:0]        data,
    input  logic [COEF_W-1:0]        coef,
    input  logic                     clr,
    output logic signed [ACC_W-1:0]  close_sum
);
    localparam int PROD_W = DATA_W + COEF_W + 1;

    logic signed [PROD_W-1:0] data_x, coef_x, prod;
    logic signed [ACC_W-1:0]  term, acc_q;

    // Widen operands and form the gated product.
    always_comb begin
        data_x = {{(PROD_W-DATA_W){data[DATA_W-1]}}, data};
        coef_x = {{(PROD_W-COEF_W){1'b0}}, coef};
        prod   = data_x * coef_x;
        term   = vld ? {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod} : '0;
    end

    // Total of the closing interval; a sample with clr belongs to the next one.
    assign close_sum = clr ? acc_q : acc_q + term;

    // Running sum: seeded on clr, accumulated otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= term;
        else          acc_q <= acc_q + term;
    end
endmodule

// File: rtl/avg_round_sat.sv
// Rounds the wide sum back to data format (half-up) and clamps on overflow.
// Assumes the sum carries SHIFT extra fraction bits beyond the data format.
module avg_round_sat #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 68,
    parameter int SHIFT  = 24
) (
    input  logic signed [ACC_W-1:0] sum_i,
    output logic [DATA_W-1:0]       q_o
);
    localparam logic signed [ACC_W-1:0] HALF = {{(ACC_W-1){1'b0}}, 1'b1} << (SHIFT-1);

    logic signed [ACC_W-1:0]  rnd, shf;
    logic [ACC_W-DATA_W:0]    hi;
    logic                     fits;

    // Half-up rounding, then an overflow test on the discarded upper bits.
    always_comb begin
        rnd  = sum_i + HALF;
        shf  = rnd >>> SHIFT;
        hi   = shf[ACC_W-1:DATA_W-1];
        fits = (&hi) | ~(|hi);
        if (fits)               q_o = shf[DATA_W-1:0];
        else if (shf[ACC_W-1])  q_o = {1'b1, {(DATA_W-1){1'b0}}};
        else                    q_o = {1'b0, {(DATA_W-1){1'b1}}};
    end
endmodule

// File: rtl/avg_seq.sv
// Interval sequencer: tracks whether a slow interval is open.
// Assumes an end strobe is valid only for an interval opened since reset or the last end.
module avg_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_start,
    input  logic slow_end,
    output logic armed,
    output logic xfer
);
    // Transfer only when an open interval is being closed.
    assign xfer = slow_end & armed;

    // Open on start, close on end; a coincident start reopens at once.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= 1'b0;
        else if (slow_start) armed <= 1'b1;
        else if (slow_end)   armed <= 1'b0;
    end
endmodule

// File: rtl/avg_downsampler.sv
// Top: fixed-interval averaging downsampler from a fast to a slow timestep.
// Assumes coef ~ 2^COEF_FRAC / n is supplied by the caller and held within an interval.
module avg_downsampler #(
    parameter int DATA_W    = avg_pkg::DEF_DATA_W,
    parameter int COEF_FRAC = avg_pkg::DEF_COEF_FRAC,
    parameter int GUARD_W   = avg_pkg::DEF_GUARD_W,
    parameter int COEF_W    = COEF_FRAC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_vld,
    input  logic [DATA_W-1:0] fast_data,
    input  logic [COEF_W-1:0] coef,
    input  logic              slow_start,
    input  logic              slow_end,
    output logic [DATA_W-1:0] avg_out,
    output logic              done
);
    localparam int ACC_W = DATA_W + COEF_W + 1 + GUARD_W;

    logic signed [ACC_W-1:0] close_sum;
    logic [DATA_W-1:0]       mean_q;
    logic                    armed, xfer;

    avg_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .vld(fast_vld), .data(fast_data),
        .coef(coef), .clr(slow_start), .close_sum(close_sum)
    );

    avg_round_sat #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT(COEF_FRAC)) u_rs (
        .sum_i(close_sum), .q_o(mean_q)
    );

    avg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .slow_start(slow_start),
        .slow_end(slow_end), .armed(armed), .xfer(xfer)
    );

    // Output register and done pulse, updated only on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= xfer;
            if (xfer) avg_out <= mean_q;
        end
    end
endmodule

// File: rtl/avg_downsampler_chk.sv
// Checker: temporal properties of the downsampler handshake, bound to the top.
module avg_downsampler_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_end,
    input logic              armed,
    input logic              done,
    input logic [DATA_W-1:0] avg_out
);
    // R8
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (avg_out == '0 && !done));
    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(slow_end) && $past(armed)));
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(avg_out));
    // R8
    stray_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_end && !armed) |=> !done);
    // R4
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_end && armed) |=> done);
endmodule

bind avg_downsampler avg_downsampler_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .slow_end(slow_end), .armed(armed),
    .done(done), .avg_out(avg_out)
);

// File: tb/sim_avg_downsampler.sv
// Bench: directed corners plus seeded random intervals against a behavioural model.
module sim_avg_downsampler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_vld = 1'b0;
    logic [31:0] fast_data = '0;
    logic [24:0] coef = '0;
    logic        slow_start = 1'b0;
    logic        slow_end = 1'b0;
    logic [31:0] avg_out;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R8";

    logic signed [127:0] m_acc = '0;
    logic                m_armed = 1'b0;
    logic [31:0]         m_out = '0;
    logic                m_done = 1'b0;

    always #2 clk = ~clk;

    avg_downsampler u0 (
        .clk(clk), .rst_n(rst_n), .fast_vld(fast_vld), .fast_data(fast_data),
        .coef(coef), .slow_start(slow_start), .slow_end(slow_end),
        .avg_out(avg_out), .done(done)
    );

    function automatic logic [31:0] rsat(input logic signed [127:0] s);
        logic signed [127:0] v;
        v = (s + (128'sd1 <<< 23)) >>> 24;
        if (v > 128'sd2147483647)         return 32'h7FFF_FFFF;
        if (v < -(128'sd2147483648))      return 32'h8000_0000;
        return v[31:0];
    endfunction

    function automatic logic [24:0] recip(input int n);
        return 25'(((64'd1 << 24) + 64'(n / 2)) / 64'(n));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare after it.
    task automatic step(input logic st, input logic en, input logic vld,
                        input logic [31:0] d, input logic [24:0] c);
        logic signed [127:0] term;
        @(negedge clk);
        slow_start = st; slow_end = en; fast_vld = vld; fast_data = d; coef = c;
        @(posedge clk);
        term = vld ? ({{96{d[31]}}, d} * {103'd0, c}) : '0;
        m_done = 1'b0;
        if (!rst_n) begin
            m_acc = '0; m_armed = 1'b0; m_out = '0;
        end else begin
            if (en && m_armed) begin
                m_out  = rsat(st ? m_acc : m_acc + term);
                m_done = 1'b1;
            end
            m_acc   = st ? term : m_acc + term;
            m_armed = st ? 1'b1 : (en ? 1'b0 : m_armed);
        end
        #1;
        check(cur_tag, {31'd0, done}, {31'd0, m_done}, "done");
        check(cur_tag, avg_out, m_out, "avg_out");
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, 32'd0, coef);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [24:0] c;
        void'($urandom(32'd1234));
        // R8: reset state
        cur_tag = "R8";
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        // R8: end with no open interval after reset
        step(1'b0, 1'b1, 1'b1, 32'h0000_1000, recip(1));
        idle(1);

        // R6: half-up ties, +1.5 LSB -> 2, -1.5 LSB -> -1
        cur_tag = "R6";
        step(1'b1, 1'b0, 1'b1, 32'd1, 25'h080_0000);
        step(1'b0, 1'b1, 1'b1, 32'd2, 25'h080_0000);
        step(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 25'h080_0000);
        step(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFE, 25'h080_0000);
        idle(2);
        // R8: second end after a transfer is ignored
        step(1'b0, 1'b1, 1'b0, 32'd0, 25'h080_0000);
        idle(1);

        // R7: overflow both ways with coef = 1.0 over 4 samples
        cur_tag = "R7";
        step(1'b1, 1'b0, 1'b1, 32'h7F00_0000, 25'h100_0000);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, 32'h7F00_0000, 25'h100_0000);
        step(1'b0, 1'b1, 1'b1, 32'h7F00_0000, 25'h100_0000);
        step(1'b1, 1'b0, 1'b1, 32'h8100_0000, 25'h100_0000);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, 32'h8100_0000, 25'h100_0000);
        step(1'b0, 1'b1, 1'b1, 32'h8100_0000, 25'h100_0000);
        idle(2);

        // R2: end+start coincident with a sample that belongs to the new interval
        cur_tag = "R2";
        c = recip(3);
        step(1'b1, 1'b0, 1'b1, 32'h0000_0300, c);
        step(1'b0, 1'b0, 1'b1, 32'h0000_0600, c);
        step(1'b0, 1'b0, 1'b1, 32'h0000_0900, c);
        step(1'b1, 1'b1, 1'b1, 32'h0100_0000, c);
        step(1'b0, 1'b0, 1'b1, 32'hFFFF_FD00, c);
        // R3: sample coincident with end is the last term
        cur_tag = "R3";
        step(1'b0, 1'b1, 1'b1, 32'h0000_0C00, c);
        idle(2);

        // R1 / R9: random intervals, lengths 1..12, chained and gapped
        for (int it = 0; it < 300; it++) begin
            int n, cnt;
            logic chain_in, end_ws, first_ws;
            n        = 1 + int'($urandom % 12);
            c        = recip(n);
            cur_tag  = (n == 1 || n == 2 || n == 4 || n == 8) ? "R1" : "R9";
            chain_in = m_armed;
            first_ws = ($urandom % 2) == 1;
            end_ws   = ($urandom % 2) == 1;
            cnt = first_ws ? 1 : 0;
            step(1'b1, chain_in, first_ws, $urandom, c);
            while (cnt < n) begin
                logic v;
                logic [31:0] d;
                v = ($urandom % 10) < 6;
                d = $urandom;
                if (v && cnt == n - 1 && end_ws) begin
                    step(1'b0, 1'b1, 1'b1, d, c);
                    cnt++;
                end else begin
                    step(1'b0, 1'b0, v, d, c);
                    if (v) cnt++;
                end
            end
            if (m_armed && ($urandom % 3) != 0) begin
                step(1'b0, 1'b1, 1'b0, 32'd0, c);
                if (($urandom % 2) == 1) idle(1 + int'($urandom % 3));
            end
        end
        if (m_armed) step(1'b0, 1'b1, 1'b0, 32'd0, c);
        idle(2);

        // R8: reset in the middle of an interval clears everything
        cur_tag = "R8";
        step(1'b1, 1'b0, 1'b1, 32'h0000_4400, recip(2));
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 32'h0000_4400, recip(2));
        idle(2);
        report();
    end
endmodule